// File: doc/BRIEF.md
# Programmable 16-bit Event Timer

This block is a bus-mapped timer for the system tick or for single timeouts. A binary prescaler divides the peripheral clock by a power of two. Its output steps a 16-bit counter that counts either up or down. In up mode the counter wraps from a programmable period limit back to zero. In down mode it reloads from that limit after passing zero, so the period is limit+1 prescaled ticks. An optional single-shot setting halts the counter on its first underflow. A timeout is then armed by loading the count register and issuing a start.

Each wrap raises a sticky flag, and so does each underflow. Software clears a flag by writing a one to the clear address and sets it by writing a one to the set address. The interrupt line is the OR of the flags that the enable register allows. The bus is a plain single-cycle write port with an address, data and write strobe. Reads return data one clock after the address is presented.

Top module: `evt_timer16`

## Requirements
- R1: After reset the control word, interrupt enable, flags and count read 0, the period limit reads 0xFFFF, the interrupt is low and the counter is stopped.
- R2: The prescale exponent n is in control bits 27:24. While the counter runs it advances once every 2^n clocks, and its first step comes exactly 2^n clocks after the start write.
- R3: The direction field is control bits 1:0. Any value other than 1 counts up. Value 0 is the normal up setting, and 2 and 3 behave the same as 0. In up mode a step from the limit gives 0 and sets flag bit 0.
- R4: Direction value 1 counts down. A step from 0 loads the limit and sets flag bit 1, so the count repeats every limit+1 steps.
- R5: Control bit 4 selects single-shot. In down mode the first underflow loads the limit and stops the counter. It stays stopped until the next start.
- R6: A write to the command register (0x04) starts the counter when bit 0 is 1 and stops it when bit 1 is 1. If both bits are 1 the counter stops. A stopped counter holds its value.
- R7: Flags read at 0x10. Writing ones at 0x14 sets flags and writing ones at 0x18 clears them. Zero bits in either write leave flags unchanged. If set and clear hit the same bit together, the set wins.
- R8: The interrupt output (registered) is high exactly when the flags AND the enable register (0x0C, bits 1:0) is nonzero. It follows each flag change on the same edge.
- R9: If a counter event and a clear write hit the same flag on one edge, the flag ends up set.
- R10: The limit is at 0x1C and the count at 0x24. Both can be written at any time. A count write takes priority over a step on the same edge.
- R11: A start write clears the prescaler, even while the counter runs. The next step comes 2^n clocks after that write, and the start edge itself causes no step.
- R12: The source select field (control bits 17:16) is stored and read back. None of its values changes the counting.
- R13: Read data is registered. It shows the addressed register as it stood before the clock edge that captures it. Unmapped and write-only addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Registered read data |
| irq_o | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check the local rules: the wrap to zero, the reload from the limit, the single-shot halt, holding while stopped, stop winning over start, event-over-clear priority, clear behaviour and the interrupt matching the enabled flags. Only the bench scenarios can show end-to-end timing, which means the exact clock of the first step after start or restart. The same holds for the period seen through the bus for each prescale value and direction. It also holds for the readback of stored fields and for the flags that build up over many periods.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int EXP_W  = 4;
  localparam int NFLAG  = 2;

  localparam int FLG_WRAP = 0;
  localparam int FLG_UNDR = 1;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CMD   = 8'h04;
  localparam logic [ADDR_W-1:0] A_IEN   = 8'h0C;
  localparam logic [ADDR_W-1:0] A_FLAG  = 8'h10;
  localparam logic [ADDR_W-1:0] A_FSET  = 8'h14;
  localparam logic [ADDR_W-1:0] A_FCLR  = 8'h18;
  localparam logic [ADDR_W-1:0] A_LIMIT = 8'h1C;
  localparam logic [ADDR_W-1:0] A_COUNT = 8'h24;

  typedef struct packed {
    logic [EXP_W-1:0] div_exp;
    logic [1:0]       src_sel;
    logic             single;
    logic [1:0]       dir;
  } ctrl_t;

  function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
    logic [DATA_W-1:0] w;
    w = '0;
    w[27:24] = c.div_exp;
    w[17:16] = c.src_sel;
    w[4]     = c.single;
    w[1:0]   = c.dir;
    return w;
  endfunction

  function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
    ctrl_t c;
    c.div_exp = w[27:24];
    c.src_sel = w[17:16];
    c.single  = w[4];
    c.dir     = w[1:0];
    return c;
  endfunction
endpackage

// File: rtl/evt_prescaler.sv
module evt_prescaler #(
  parameter int EXP_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             restart,
  input  logic [EXP_W-1:0] div_exp,
  output logic             tick
);
  localparam int DIV_W = (1 << EXP_W) - 1;

  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < int'(div_exp)) mask[i] = 1'b1;
    end
  end

  assign tick = run && !restart && ((div_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst || restart || !run) div_q <= '0;
    else                        div_q <= div_q + 1'b1;
  end

  // R2: with exponent 0 a running, non-restarted counter steps every clock
  a_r2_div_one: assert property (@(posedge clk) disable iff (rst)
    (run && !restart && div_exp == '0) |-> tick);
  // R11: a restart edge never produces a step
  a_r11_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |-> !tick);
endmodule

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic             dir_down,
  input  logic             single,
  input  logic [CNT_W-1:0] limit,
  input  logic             cnt_we,
  input  logic [CNT_W-1:0] cnt_wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic             running_q,
  output logic             wrap_evt,
  output logic             undr_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_limit, at_zero;

  assign at_limit = (cnt_q == limit);
  assign at_zero  = (cnt_q == '0);
  assign wrap_evt = tick && !dir_down && at_limit && !cnt_we;
  assign undr_evt = tick &&  dir_down && at_zero  && !cnt_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      if (cnt_we)          cnt_q <= cnt_wdata;
      else if (tick) begin
        if (dir_down)      cnt_q <= at_zero  ? limit : cnt_q - ONE;
        else               cnt_q <= at_limit ? '0    : cnt_q + ONE;
      end
      if (stop)                       running_q <= 1'b0;
      else if (start)                 running_q <= 1'b1;
      else if (undr_evt && single)    running_q <= 1'b0;
    end
  end

  a_r3_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    (tick && !dir_down && cnt_q == limit && !cnt_we) |=> cnt_q == '0);
  a_r4_reload: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_down && cnt_q == '0 && !cnt_we) |=> cnt_q == $past(limit));
  a_r5_single_halt: assert property (@(posedge clk) disable iff (rst)
    (tick && dir_down && single && cnt_q == '0 && !cnt_we && !start) |=> !running_q);
  a_r6_hold_stopped: assert property (@(posedge clk) disable iff (rst)
    (!running_q && !cnt_we) |=> $stable(cnt_q));
  a_r10_write_first: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == $past(cnt_wdata));
endmodule

// File: rtl/evt_flags.sv
module evt_flags #(
  parameter int NF = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NF-1:0] hw_evt,
  input  logic [NF-1:0] set_w,
  input  logic [NF-1:0] clr_w,
  input  logic          ien_we,
  input  logic [NF-1:0] ien_wdata,
  output logic [NF-1:0] flags_q,
  output logic [NF-1:0] ien_q,
  output logic          irq_q
);
  logic [NF-1:0] flags_d, ien_d;

  assign flags_d = (flags_q & ~clr_w) | set_w | hw_evt;
  assign ien_d   = ien_we ? ien_wdata : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      ien_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      ien_q   <= ien_d;
      irq_q   <= |(flags_d & ien_d);
    end
  end

  for (genvar i = 0; i < NF; i++) begin : g_chk
    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
      hw_evt[i] |=> flags_q[i]);
    a_r7_clear: assert property (@(posedge clk) disable iff (rst)
      (clr_w[i] && !set_w[i] && !hw_evt[i]) |=> !flags_q[i]);
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
      (flags_q[i] && !clr_w[i]) |=> flags_q[i]);
  end

  a_r8_irq_match: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(flags_q & ien_q));
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
  import evt_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  localparam int PAD_C = DATA_W - CNT_W;
  localparam int PAD_F = DATA_W - NFLAG;

  ctrl_t             ctrl_q;
  logic [CNT_W-1:0]  limit_q;
  logic [CNT_W-1:0]  cnt_w;
  logic              run_w, tick_w, wrap_w, undr_w;
  logic [NFLAG-1:0]  flags_w, ien_w, hw_evt, set_w, clr_w;
  logic              wr_ctrl, wr_cmd, wr_ien, wr_fset, wr_fclr, wr_limit, wr_cnt;
  logic              cmd_start, cmd_stop;

  assign wr_ctrl  = bus_we && (bus_addr == A_CTRL);
  assign wr_cmd   = bus_we && (bus_addr == A_CMD);
  assign wr_ien   = bus_we && (bus_addr == A_IEN);
  assign wr_fset  = bus_we && (bus_addr == A_FSET);
  assign wr_fclr  = bus_we && (bus_addr == A_FCLR);
  assign wr_limit = bus_we && (bus_addr == A_LIMIT);
  assign wr_cnt   = bus_we && (bus_addr == A_COUNT);

  assign cmd_start = wr_cmd && bus_wdata[0];
  assign cmd_stop  = wr_cmd && bus_wdata[1];
  assign set_w     = wr_fset ? bus_wdata[NFLAG-1:0] : '0;
  assign clr_w     = wr_fclr ? bus_wdata[NFLAG-1:0] : '0;

  always_comb begin
    hw_evt = '0;
    hw_evt[FLG_WRAP] = wrap_w;
    hw_evt[FLG_UNDR] = undr_w;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      limit_q <= '1;
    end else begin
      if (wr_ctrl)  ctrl_q  <= unpack_ctrl(bus_wdata);
      if (wr_limit) limit_q <= bus_wdata[CNT_W-1:0];
    end
  end

  evt_prescaler #(.EXP_W(EXP_W)) u_presc (
    .clk     (clk),
    .rst     (rst),
    .run     (run_w),
    .restart (cmd_start),
    .div_exp (ctrl_q.div_exp),
    .tick    (tick_w)
  );

  evt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick_w),
    .start     (cmd_start),
    .stop      (cmd_stop),
    .dir_down  (ctrl_q.dir == 2'd1),
    .single    (ctrl_q.single),
    .limit     (limit_q),
    .cnt_we    (wr_cnt),
    .cnt_wdata (bus_wdata[CNT_W-1:0]),
    .cnt_q     (cnt_w),
    .running_q (run_w),
    .wrap_evt  (wrap_w),
    .undr_evt  (undr_w)
  );

  evt_flags #(.NF(NFLAG)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .hw_evt    (hw_evt),
    .set_w     (set_w),
    .clr_w     (clr_w),
    .ien_we    (wr_ien),
    .ien_wdata (bus_wdata[NFLAG-1:0]),
    .flags_q   (flags_w),
    .ien_q     (ien_w),
    .irq_q     (irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (bus_addr)
        A_CTRL:  bus_rdata <= pack_ctrl(ctrl_q);
        A_IEN:   bus_rdata <= {{PAD_F{1'b0}}, ien_w};
        A_FLAG:  bus_rdata <= {{PAD_F{1'b0}}, flags_w};
        A_LIMIT: bus_rdata <= {{PAD_C{1'b0}}, limit_q};
        A_COUNT: bus_rdata <= {{PAD_C{1'b0}}, cnt_w};
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R6: stop wins over a simultaneous start
  a_r6_stop_wins: assert property (@(posedge clk) disable iff (rst)
    cmd_stop |=> !run_w);
  // R6: a start alone always runs the counter
  a_r6_start_runs: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cmd_stop) |=> run_w);
endmodule

// File: tb/evt_timer16_bench.sv
module evt_timer16_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wr_cyc = 0;
  int rd_cyc = 0;
  bit reported = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evt_timer16 u_evt_timer16 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0;
    wr_cyc = cyc;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(posedge clk); #1;
    rd_cyc = cyc;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // Step-by-step model built from R3, R4, R5
  task automatic model(input bit down, input bit single, input int c0, input int lim,
                       input int steps, output int v, output bit wrapped, output bit undr);
    v = c0; wrapped = 0; undr = 0;
    for (int i = 0; i < steps; i++) begin
      if (down) begin
        if (v == 0) begin
          v = lim; undr = 1;
          if (single) break;
        end else v = v - 1;
      end else begin
        if (v == lim) begin v = 0; wrapped = 1; end
        else v = (v + 1) & 16'hFFFF;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    report();
  end

  initial begin
    logic [31:0] rv;
    logic [31:0] r2;
    int es;
    int v;
    bit fw, fu;
    void'($urandom(32'h00C0FFEE));

    idle(3);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    rd(8'h00, rv); chk("R1 ctrl", rv, 32'h0);
    rd(8'h1C, rv); chk("R1 limit", rv, 32'hFFFF);
    rd(8'h24, rv); chk("R1 count", rv, 32'h0);
    rd(8'h10, rv); chk("R1 flags", rv, 32'h0);
    rd(8'h0C, rv); chk("R1 enable", rv, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    idle(5);
    rd(8'h24, rv); chk("R1 stopped after reset", rv, 32'h0);

    // R13 write-only address reads zero
    rd(8'h04, rv); chk("R13 cmd reads zero", rv, 32'h0);

    // R10 count write while stopped holds
    wr(8'h24, 32'h1234);
    idle(10);
    rd(8'h24, rv); chk("R10 count load held", rv, 32'h1234);

    // R6 start+stop together stays stopped
    wr(8'h24, 32'h5);
    wr(8'h04, 32'h3);
    idle(10);
    rd(8'h24, rv); chk("R6 stop wins", rv, 32'h5);

    // R2 first step exactly 2^n clocks after start (n=2, up)
    wr(8'h00, 32'h0200_0000);
    wr(8'h24, 32'h0);
    wr(8'h04, 32'h1);
    idle(3);
    rd(8'h24, rv); chk("R2 before 4th clock", rv, 32'h0);
    rd(8'h24, rv); chk("R2 at 4th clock", rv, 32'h1);

    // R6 stop while running holds value
    wr(8'h04, 32'h2);
    rd(8'h24, rv);
    idle(12);
    rd(8'h24, r2); chk("R6 hold after stop", r2, rv);

    // R11 restart clears prescaler (n=3)
    wr(8'h00, 32'h0300_0000);
    wr(8'h24, 32'h0);
    wr(8'h04, 32'h1);
    idle(5);
    wr(8'h04, 32'h1);
    idle(7);
    rd(8'h24, rv); chk("R11 no step before 8 clocks", rv, 32'h0);
    rd(8'h24, rv); chk("R11 step at 8 clocks", rv, 32'h1);
    wr(8'h04, 32'h2);

    // R3 up wrap and wrap flag (bit 0)
    wr(8'h18, 32'h3);
    wr(8'h00, 32'h0);
    wr(8'h1C, 32'h3);
    wr(8'h24, 32'h3);
    wr(8'h04, 32'h1);
    rd(8'h24, rv); chk("R3 at limit", rv, 32'h3);
    rd(8'h24, rv); chk("R3 wrap to zero", rv, 32'h0);
    wr(8'h04, 32'h2);
    rd(8'h10, rv); chk("R3 wrap flag", rv, 32'h1);

    // R4 down reload and underflow flag (bit 1)
    wr(8'h18, 32'h3);
    wr(8'h00, 32'h1);
    wr(8'h1C, 32'h4);
    wr(8'h24, 32'h0);
    wr(8'h04, 32'h1);
    rd(8'h24, rv); chk("R4 at zero", rv, 32'h0);
    rd(8'h24, rv); chk("R4 reload limit", rv, 32'h4);
    rd(8'h24, rv); chk("R4 decrement", rv, 32'h3);
    wr(8'h04, 32'h2);
    rd(8'h10, rv); chk("R4 underflow flag", rv, 32'h2);

    // R5 single-shot halts on first underflow
    wr(8'h18, 32'h3);
    wr(8'h00, 32'h11);
    wr(8'h1C, 32'h7);
    wr(8'h24, 32'h2);
    wr(8'h04, 32'h1);
    idle(20);
    rd(8'h24, rv); chk("R5 halted at limit", rv, 32'h7);
    idle(10);
    rd(8'h24, rv); chk("R5 stays halted", rv, 32'h7);
    rd(8'h10, rv); chk("R5 underflow flag", rv, 32'h2);

    // R7 set / clear by writing ones
    wr(8'h18, 32'h3);
    wr(8'h14, 32'h1);
    rd(8'h10, rv); chk("R7 set bit0", rv, 32'h1);
    wr(8'h18, 32'h0);
    rd(8'h10, rv); chk("R7 zero clear no effect", rv, 32'h1);
    wr(8'h14, 32'h0);
    rd(8'h10, rv); chk("R7 zero set no effect", rv, 32'h1);
    wr(8'h18, 32'h1);
    rd(8'h10, rv); chk("R7 clear bit0", rv, 32'h0);
    wr(8'h14, 32'h3);
    rd(8'h10, rv); chk("R7 set both", rv, 32'h3);
    wr(8'h18, 32'h3);
    rd(8'h10, rv); chk("R7 clear both", rv, 32'h0);

    // R8 interrupt masking (enable bit 1 only)
    wr(8'h0C, 32'h2);
    wr(8'h14, 32'h1);
    chk("R8 masked flag", {31'b0, irq_o}, 32'h0);
    wr(8'h14, 32'h2);
    chk("R8 enabled flag", {31'b0, irq_o}, 32'h1);
    wr(8'h18, 32'h2);
    chk("R8 cleared", {31'b0, irq_o}, 32'h0);
    wr(8'h0C, 32'h3);
    chk("R8 enable raises", {31'b0, irq_o}, 32'h1);
    wr(8'h18, 32'h3);
    wr(8'h0C, 32'h0);

    // R9 underflow beats a clear on the same edge
    wr(8'h00, 32'h1);
    wr(8'h1C, 32'h5);
    wr(8'h24, 32'h1);
    wr(8'h04, 32'h1);
    idle(1);
    wr(8'h18, 32'h2);
    rd(8'h10, rv); chk("R9 event wins over clear", rv & 32'h2, 32'h2);
    wr(8'h04, 32'h2);

    // Random mix: R2 R3 R4 R5 R12
    for (int it = 0; it < 40; it++) begin
      int ex, dir, sgl, src, lim, c0, k;
      bit down;
      logic [31:0] cw;
      ex  = $urandom % 4;
      dir = $urandom % 4;
      sgl = $urandom % 2;
      src = $urandom % 4;
      lim = 3 + ($urandom % 20);
      c0  = $urandom % (lim + 1);
      down = (dir == 1);
      cw = (32'(ex) << 24) | (32'(src) << 16) | (32'(sgl) << 4) | 32'(dir);
      wr(8'h04, 32'h2);
      wr(8'h18, 32'h3);
      wr(8'h00, cw);
      wr(8'h1C, 32'(lim));
      wr(8'h24, 32'(c0));
      wr(8'h04, 32'h1);
      es = wr_cyc;
      idle($urandom % 60);
      rd(8'h24, rv);
      k = rd_cyc - 1 - es;
      model(down, sgl[0], c0, lim, k >> ex, v, fw, fu);
      chk("R4 R3 R2 random count", rv, 32'(v));
      rd(8'h10, rv);
      k = rd_cyc - 1 - es;
      model(down, sgl[0], c0, lim, k >> ex, v, fw, fu);
      chk("R5 random flags", rv, {30'b0, fu, fw});
      rd(8'h00, rv);
      chk("R12 ctrl readback", rv, cw);
    end

    report();
  end
endmodule